// File: doc/BRIEF.md
# UART Channel Command Decoder

This block sits behind the command-register address of one UART channel. Each byte written there is split into two parts. The low four bits are independent switches that turn the transmitter and the receiver on or off. The high four bits select one miscellaneous command. The decoder turns these into registered enable levels, one-cycle reset and clear pulses, and held mode levels. The mode levels cover the request-to-send pin, the counter/timer timeout mode, the power-down state and the mode-register pointer. The serial shifters, FIFOs, status registers and counter/timer sit elsewhere and consume these outputs.

Two rules govern the high nibble. First, accepted miscellaneous commands must be at least `MIN_GAP` clock edges apart. A command that arrives too early is dropped, and a sticky violation flag records the drop. Second, once power-down is entered, the only write that has any effect is the power-down exit command.

Top module: `ucmd_decoder`

## Requirements
- R1: After reset, `tx_en`, `rx_en`, `tmo_mode`, `pwr_down`, `space_viol` and every pulse output are 0. `rts_n` is 1 and `mr_ptr` is 0.
- R2: In a write, bit 3 clears `tx_en`, bit 2 sets `tx_en`, bit 1 clears `rx_en` and bit 0 sets `rx_en`. The new level is visible one clock after the write edge.
- R3: If one write sets both the on bit and the off bit for the same direction (bits 3 and 2, or bits 1 and 0), the off bit wins.
- R4: Code 0010 in bits 7:4 raises `rx_rst_p` for one cycle and forces `rx_en` to 0. Code 0011 raises `tx_rst_p` for one cycle and forces `tx_en` to 0. In both cases the forced 0 wins over an enable bit in the same write.
- R5: Code 0100 raises `err_clr_p` for one cycle. Code 0101 raises `brk_clr_p` for one cycle.
- R6: Code 1000 drives `rts_n` to 0. Code 1001 drives `rts_n` to 1. The level holds until changed.
- R7: Code 1010 sets `tmo_mode` and raises `tmo_arm_p` for one cycle; this pulse tells the counter/timer to stop, enter counter mode and drop its ready flag. Code 1100 clears `tmo_mode` without raising any pulse.
- R8: Code 0001 sets `mr_ptr` to 1. Code 1011 sets `mr_ptr` to 0.
- R9: Code 1110 sets `pwr_down`. While `pwr_down` is 1, a write with bits 7:4 not equal to 1111 changes no output, including the bit 3..0 effects and `space_viol`. Code 1111 clears `pwr_down`.
- R10: Suppose a nonzero code is accepted at clock edge k. The next nonzero code is accepted no earlier than edge k+3. A code arriving earlier has no effect, but the bit 3..0 effects of that same write still apply.
- R11: A dropped code sets `space_viol` to 1. It stays 1 until reset.
- R12: Codes 0110, 0111 and 1101 change no output, but they do start a spacing window. Code 0000 changes nothing and starts no spacing window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the command byte |
| wr_data | input | 8 | Command byte |
| tx_en | output | 1 | Transmitter enable level |
| rx_en | output | 1 | Receiver enable level |
| tx_rst_p | output | 1 | Transmitter reset pulse |
| rx_rst_p | output | 1 | Receiver reset and FIFO flush pulse |
| err_clr_p | output | 1 | Clear pulse for the received-error status bits |
| brk_clr_p | output | 1 | Clear pulse for the break-change interrupt bit |
| rts_n | output | 1 | Request-to-send, active low |
| tmo_mode | output | 1 | Timeout mode owns the counter/timer |
| tmo_arm_p | output | 1 | Pulse on timeout-mode entry |
| pwr_down | output | 1 | Power-down state |
| mr_ptr | output | MRP_W | Mode-register pointer value |
| space_viol | output | 1 | Sticky flag for a dropped, too-early command |

## Verification
Every output is registered, so each effect of a write sampled at clock edge k is due in the cycle right after k and nowhere else. Pulses are visible in that one cycle only; levels are visible from that cycle onward. The driver applies a byte at the falling edge and pushes the full expected output vector for the next rising edge into a queue. The monitor pops that entry a quarter period after the rising edge and compares every output at once, so a pulse that comes a cycle early, a cycle late or lasts two cycles is reported. The spacing rule is tested with a command offered at one and two edges after an accepted one and then at exactly three edges after it.

// File: rtl/ucmd_pkg.sv
package ucmd_pkg;

  typedef enum logic [3:0] {
    MC_NOP     = 4'h0,
    MC_MR_ONE  = 4'h1,
    MC_RX_RST  = 4'h2,
    MC_TX_RST  = 4'h3,
    MC_ERR_CLR = 4'h4,
    MC_BRK_CLR = 4'h5,
    MC_BRK_ON  = 4'h6,
    MC_BRK_OFF = 4'h7,
    MC_RTS_LO  = 4'h8,
    MC_RTS_HI  = 4'h9,
    MC_TMO_ON  = 4'hA,
    MC_MR_ZERO = 4'hB,
    MC_TMO_OFF = 4'hC,
    MC_SPARE   = 4'hD,
    MC_PD_ON   = 4'hE,
    MC_PD_OFF  = 4'hF
  } misc_code_e;

  // Next enable level of one direction: a forced reset or an off bit beats an on bit.
  function automatic logic dir_next(input logic cur, input logic off_b,
                                    input logic on_b, input logic kill);
    if (kill || off_b) return 1'b0;
    if (on_b) return 1'b1;
    return cur;
  endfunction

  // A code takes part in the spacing rule unless it is the no-op.
  function automatic logic code_spaced(input misc_code_e c);
    return c != MC_NOP;
  endfunction

  // A code may pass while powered down only if it is the exit.
  function automatic logic code_passes_pd(input misc_code_e c, input logic pd);
    return !pd || (c == MC_PD_OFF);
  endfunction

endpackage

// File: rtl/ucmd_gap.sv
module ucmd_gap #(
  parameter int unsigned MIN_GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ok,
  output logic viol
);
  localparam int unsigned CW = $clog2(MIN_GAP + 1);
  localparam logic [CW-1:0] RELOAD = CW'(MIN_GAP - 1);

  logic [CW-1:0] left_q;
  logic          drop;

  assign ok   = req && (left_q == '0);
  assign drop = req && (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      viol   <= 1'b0;
    end else begin
      if (ok) left_q <= RELOAD;
      else if (left_q != '0) left_q <= left_q - 1'b1;
      if (drop) viol <= 1'b1;
    end
  end

  // Independent edge counter since the last accepted command, used only by the checks.
  logic [CW-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_q <= CW'(MIN_GAP);
    else if (ok) since_q <= CW'(1);
    else if (since_q != CW'(MIN_GAP)) since_q <= since_q + 1'b1;
  end

  AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> since_q == CW'(MIN_GAP)); // R10
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol); // R11
  AST_VIOL_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req && since_q != CW'(MIN_GAP)) |=> viol); // R11

endmodule

// File: rtl/ucmd_dirctl.sv
module ucmd_dirctl
  import ucmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       live,
  input  logic [3:0] low_bits,
  input  logic [1:0] kill,
  output logic [1:0] en
);
  // Direction index 1 = transmitter (bits 3/2), 0 = receiver (bits 1/0).
  for (genvar g = 0; g < 2; g++) begin : g_dir
    logic off_b, on_b, nxt;
    assign off_b = live && low_bits[2*g+1];
    assign on_b  = live && low_bits[2*g];
    assign nxt   = dir_next(en[g], off_b, on_b, kill[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en[g] <= 1'b0;
      else        en[g] <= nxt;
    end

    AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (off_b && on_b) |=> !en[g]); // R3
    AST_ON_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (on_b && !off_b && !kill[g]) |=> en[g]); // R2
  end

endmodule

// File: rtl/ucmd_misc.sv
module ucmd_misc
  import ucmd_pkg::*;
#(
  parameter int unsigned MRP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ok,
  input  misc_code_e       code,
  output logic             tx_kill,
  output logic             rx_kill,
  output logic             tx_rst_p,
  output logic             rx_rst_p,
  output logic             err_clr_p,
  output logic             brk_clr_p,
  output logic             tmo_arm_p,
  output logic             rts_n,
  output logic             tmo_mode,
  output logic             pwr_down,
  output logic [MRP_W-1:0] mr_ptr
);
  localparam logic [MRP_W-1:0] MR_FIRST = MRP_W'(1);

  logic hit_rts_lo, hit_rts_hi, hit_tmo_on, hit_tmo_off, hit_pd_on, hit_pd_off;
  logic hit_mr_one, hit_mr_zero;

  assign tx_kill     = ok && code == MC_TX_RST;
  assign rx_kill     = ok && code == MC_RX_RST;
  assign hit_rts_lo  = ok && code == MC_RTS_LO;
  assign hit_rts_hi  = ok && code == MC_RTS_HI;
  assign hit_tmo_on  = ok && code == MC_TMO_ON;
  assign hit_tmo_off = ok && code == MC_TMO_OFF;
  assign hit_pd_on   = ok && code == MC_PD_ON;
  assign hit_pd_off  = ok && code == MC_PD_OFF;
  assign hit_mr_one  = ok && code == MC_MR_ONE;
  assign hit_mr_zero = ok && code == MC_MR_ZERO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rst_p  <= 1'b0;
      rx_rst_p  <= 1'b0;
      err_clr_p <= 1'b0;
      brk_clr_p <= 1'b0;
      tmo_arm_p <= 1'b0;
    end else begin
      tx_rst_p  <= tx_kill;
      rx_rst_p  <= rx_kill;
      err_clr_p <= ok && code == MC_ERR_CLR;
      brk_clr_p <= ok && code == MC_BRK_CLR;
      tmo_arm_p <= hit_tmo_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_n    <= 1'b1;
      tmo_mode <= 1'b0;
      pwr_down <= 1'b0;
      mr_ptr   <= '0;
    end else begin
      if (hit_rts_lo)       rts_n <= 1'b0;
      else if (hit_rts_hi)  rts_n <= 1'b1;
      if (hit_tmo_on)       tmo_mode <= 1'b1;
      else if (hit_tmo_off) tmo_mode <= 1'b0;
      if (hit_pd_on)        pwr_down <= 1'b1;
      else if (hit_pd_off)  pwr_down <= 1'b0;
      if (hit_mr_one)       mr_ptr <= MR_FIRST;
      else if (hit_mr_zero) mr_ptr <= '0;
    end
  end

  AST_RTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rts_lo |=> !rts_n); // R6
  AST_TMO_ARM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_arm_p |=> !tmo_arm_p); // R7
  AST_PULSE_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_rst_p, rx_rst_p, err_clr_p, brk_clr_p, tmo_arm_p})); // R5

endmodule

// File: rtl/ucmd_decoder.sv
module ucmd_decoder
  import ucmd_pkg::*;
#(
  parameter int unsigned MIN_GAP = 3,
  parameter int unsigned MRP_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic             tx_en,
  output logic             rx_en,
  output logic             tx_rst_p,
  output logic             rx_rst_p,
  output logic             err_clr_p,
  output logic             brk_clr_p,
  output logic             rts_n,
  output logic             tmo_mode,
  output logic             tmo_arm_p,
  output logic             pwr_down,
  output logic [MRP_W-1:0] mr_ptr,
  output logic             space_viol
);
  misc_code_e code;
  logic       low_live;
  logic       misc_req;
  logic       misc_ok;
  logic       tx_kill, rx_kill;
  logic [1:0] en_vec;

  assign code     = misc_code_e'(wr_data[7:4]);
  assign low_live = wr_en && !pwr_down;
  assign misc_req = wr_en && code_spaced(code) && code_passes_pd(code, pwr_down);

  ucmd_gap #(.MIN_GAP(MIN_GAP)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (misc_req),
    .ok    (misc_ok),
    .viol  (space_viol)
  );

  ucmd_misc #(.MRP_W(MRP_W)) u_misc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ok        (misc_ok),
    .code      (code),
    .tx_kill   (tx_kill),
    .rx_kill   (rx_kill),
    .tx_rst_p  (tx_rst_p),
    .rx_rst_p  (rx_rst_p),
    .err_clr_p (err_clr_p),
    .brk_clr_p (brk_clr_p),
    .tmo_arm_p (tmo_arm_p),
    .rts_n     (rts_n),
    .tmo_mode  (tmo_mode),
    .pwr_down  (pwr_down),
    .mr_ptr    (mr_ptr)
  );

  ucmd_dirctl u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .live     (low_live),
    .low_bits (wr_data[3:0]),
    .kill     ({tx_kill, rx_kill}),
    .en       (en_vec)
  );

  assign tx_en = en_vec[1];
  assign rx_en = en_vec[0];

  AST_PD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && wr_en && wr_data[7:4] != 4'hF)
      |=> ($stable({tx_en, rx_en, rts_n, tmo_mode, mr_ptr, space_viol, pwr_down})
           && !tx_rst_p && !rx_rst_p && !err_clr_p && !brk_clr_p && !tmo_arm_p)); // R9
  AST_TXRST_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_p |-> !tx_en); // R4
  AST_RXRST_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_p |-> !rx_en); // R4

endmodule

// File: tb/sim_ucmd_decoder.sv
module sim_ucmd_decoder;
  localparam time PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_en, rx_en, tx_rst_p, rx_rst_p, err_clr_p, brk_clr_p;
  logic       rts_n, tmo_mode, tmo_arm_p, pwr_down, space_viol;
  logic [1:0] mr_ptr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ucmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_en(tx_en), .rx_en(rx_en), .tx_rst_p(tx_rst_p), .rx_rst_p(rx_rst_p),
    .err_clr_p(err_clr_p), .brk_clr_p(brk_clr_p), .rts_n(rts_n),
    .tmo_mode(tmo_mode), .tmo_arm_p(tmo_arm_p), .pwr_down(pwr_down),
    .mr_ptr(mr_ptr), .space_viol(space_viol)
  );

  typedef struct {
    logic [13:0] v;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  // Reference state, kept in the bench's own terms.
  bit m_tx, m_rx, m_rts = 1'b1, m_tmo, m_pd, m_viol;
  bit [1:0] m_mr;
  int edge_no = 0;
  int last_acc = -100;

  function automatic logic [13:0] actual_vec();
    return {tx_en, rx_en, tx_rst_p, rx_rst_p, err_clr_p, brk_clr_p,
            rts_n, tmo_mode, tmo_arm_p, pwr_down, mr_ptr, space_viol};
  endfunction

  task automatic step(input bit we, input logic [7:0] d, input string tag);
    bit p_tx = 0, p_rx = 0, p_err = 0, p_brk = 0, p_arm = 0;
    bit spaced, early;
    logic [3:0] c;
    exp_t e;
    @(negedge clk);
    wr_en = we;
    wr_data = d;
    c = d[7:4];
    if (we) begin
      spaced = (c != 4'h0) && (!m_pd || c == 4'hF);
      early  = (edge_no - last_acc) < 3;
      if (!m_pd) begin
        if (d[3]) m_tx = 0; else if (d[2]) m_tx = 1;
        if (d[1]) m_rx = 0; else if (d[0]) m_rx = 1;
      end
      if (spaced && early) m_viol = 1;
      if (spaced && !early) begin
        last_acc = edge_no;
        case (c)
          4'h1: m_mr = 2'd1;
          4'h2: begin p_rx = 1; m_rx = 0; end
          4'h3: begin p_tx = 1; m_tx = 0; end
          4'h4: p_err = 1;
          4'h5: p_brk = 1;
          4'h8: m_rts = 0;
          4'h9: m_rts = 1;
          4'hA: begin m_tmo = 1; p_arm = 1; end
          4'hB: m_mr = 2'd0;
          4'hC: m_tmo = 0;
          4'hE: m_pd = 1;
          4'hF: m_pd = 0;
          default: ;
        endcase
      end
    end
    e.v = {m_tx, m_rx, p_tx, p_rx, p_err, p_brk, m_rts, m_tmo, p_arm, m_pd, m_mr, m_viol};
    e.tag = tag;
    exp_q.push_back(e);
    edge_no++;
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    step(1'b1, d, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, tag);
  endtask

  // Monitor: pops one expected vector per rising edge, a quarter period later.
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        logic [13:0] a;
        e = exp_q.pop_front();
        a = actual_vec();
        checks++;
        if (a !== e.v) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", e.tag, a, e.v);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #(PERIOD/4);
    checks++;
    // R1: reset values
    if (actual_vec() !== {2'b00, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0}) begin
      errors++;
      $display("FAIL R1 actual=%h expected=%h", actual_vec(), 14'h0080);
    end
    idle(2, "R1");
    // R2: enable bits
    wr(8'h04, "R2"); wr(8'h01, "R2"); wr(8'h08, "R2"); wr(8'h02, "R2"); wr(8'h05, "R2");
    // R3: on and off together
    wr(8'h0C, "R3"); wr(8'h03, "R3"); wr(8'h05, "R3"); wr(8'h0F, "R3");
    // R6: request-to-send
    wr(8'h80, "R6"); idle(2, "R6"); wr(8'h90, "R6"); idle(2, "R6");
    // R10: early codes dropped, low bits still act
    wr(8'h80, "R10"); wr(8'h95, "R10"); wr(8'h90, "R10"); wr(8'h90, "R10");
    // R11: flag stays set
    idle(4, "R11"); wr(8'h00, "R11");
    // R5: clear pulses
    idle(2, "R5"); wr(8'h40, "R5"); idle(2, "R5"); wr(8'h50, "R5"); idle(2, "R5");
    // R8: pointer
    wr(8'h10, "R8"); idle(2, "R8"); wr(8'hB0, "R8"); idle(2, "R8");
    // R7: timeout mode
    wr(8'hA0, "R7"); idle(2, "R7"); wr(8'hC0, "R7"); idle(2, "R7");
    // R4: channel resets beat enables
    wr(8'h05, "R4"); wr(8'h21, "R4"); idle(2, "R4");
    wr(8'h05, "R4"); wr(8'h34, "R4"); idle(2, "R4");
    // R12: codes without outputs still spend the window; no-op does not
    wr(8'h60, "R12"); wr(8'h80, "R12"); idle(2, "R12");
    wr(8'h00, "R12"); wr(8'h80, "R12"); idle(2, "R12");
    wr(8'hD0, "R12"); idle(2, "R12"); wr(8'h70, "R12"); idle(2, "R12");
    wr(8'h90, "R12"); idle(2, "R12");
    // R9: power-down lockout and exit
    wr(8'h05, "R9"); wr(8'hE0, "R9"); idle(2, "R9");
    wr(8'h0A, "R9"); wr(8'h80, "R9"); wr(8'h20, "R9"); wr(8'hA0, "R9");
    idle(2, "R9"); wr(8'hF0, "R9"); idle(2, "R9");
    wr(8'h0A, "R9"); wr(8'h80, "R9"); idle(2, "R9");
    idle(2, "R9");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule